// File: doc/BRIEF.md
# Adaptive Precision and Sample-Rate Controller

This block sits at the head of a packet receiver's baseband datapath. It scales the datapath's precision and sampling rate to the quality of the received signal. While a packet's preamble and start-of-frame delimiter are being received, the synchronization logic needs full precision at the full rate. So the controller holds a fixed 8-bit word length and divide-by-one there, whatever the selection inputs say.

The first clock of the data portion triggers three actions. The controller captures the externally chosen word length and requested rate. It rounds that rate up to the nearest rate the 30 MHz master clock can give by integer division. It then clears its sample pipeline so that no sample from the earlier setting reaches the output.

Samples are reduced by an arithmetic right shift that keeps the sign. The shift discards the low bits, so higher-order bits stop toggling downstream. A modulo-D counter produces a one-cycle sample-enable strobe every D master-clock cycles. When the packet ends, or the data phase drops, the controller goes back to full settings.

Top module: `precision_rate_ctrl`

## Requirements
- R1: After reset, wl_active is 3 (8-bit), div_active is 1, out_valid is low and samp_out is zero.
- R2: Word-length codes are 0, 1, 2 and 3, for 1, 2, 4 and 8 bits. Each sample taken on an enable is the input arithmetically shifted right by IN_W minus the active word length, with the sign kept.
- R3: In 1-bit mode (code 0), every valid output is all zeros for a non-negative input and all ones for a negative one.
- R4: samp_en is high for exactly one cycle in every div_active cycles. The counter restarts on any change of setting, and the first strobe comes in the cycle right after the change.
- R5: The divisor is the largest of 30, 15, 10, 6, 5, 3, 2 and 1 for which 30/D is at least the requested rate in Msps. A request of 0 or 1 gives 30, and a request above 30 gives 1 (for example, 13 gives 2, which is 15 Msps).
- R6: Whenever the block is not in the data portion of an active packet, the active setting is 8-bit, divisor 1, regardless of wl_sel and rate_req.
- R7: On the first cycle with pkt_active and data_phase both high, wl_sel and rate_req are captured. The captured setting is held for the rest of the data portion even if the selection inputs change.
- R8: At data start the pipeline is cleared and out_valid stays low until PIPE_DEPTH enables have passed. The first out_valid comes with the PIPE_DEPTH-th enable after the flush, and reset counts as a flush.
- R9: One cycle after pkt_active or data_phase falls, the setting is back to 8-bit, divisor 1, and samp_en strobes every cycle.
- R10: Outside a flush, out_valid pulses once per enable, and samp_out then carries the sample requantized PIPE_DEPTH enables earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 30 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_active | input | 1 | High while a packet is being received |
| data_phase | input | 1 | High in the data portion, low in preamble/delimiter |
| wl_sel | input | 2 | Selected word-length code for data |
| rate_req | input | RATE_W | Requested data sample rate in Msps |
| samp_in | input | IN_W | Signed input sample |
| samp_en | output | 1 | Sample-enable strobe |
| samp_out | output | IN_W | Requantized, pipelined sample |
| out_valid | output | 1 | Strobe marking a valid samp_out |
| wl_active | output | 2 | Word-length code in force |
| div_active | output | 5 | Rate divisor in force |

## Verification
The data-start flush and a sample-enable strobe land in the same clock edge on every packet, because the preamble runs at divisor 1 and so enables every cycle. The flush must win: the incoming sample is dropped, the pipeline is zeroed and the flush count is reloaded. A reference model in the bench applies that precedence and checks out_valid, samp_out and samp_en every cycle, across random packet lengths and settings, including back-to-back packets with no idle gap.

// File: rtl/prc_pkg.sv
`timescale 1ns/100ps
package prc_pkg;
   localparam int MASTER_MHZ = 30;
   localparam int DIV_W      = $clog2(MASTER_MHZ + 1);
   localparam int WL_CODES   = 4;

   typedef enum logic [1:0] {
      WL_1 = 2'd0,
      WL_2 = 2'd1,
      WL_4 = 2'd2,
      WL_8 = 2'd3
   } wl_code_e;

   localparam logic [1:0] WL_FULL = WL_8;

   // largest integer divisor of the master rate still meeting the request
   function automatic logic [DIV_W-1:0] pick_divisor(input int unsigned rate);
      logic [DIV_W-1:0] res;
      res = DIV_W'(1);
      for (int d = 1; d <= MASTER_MHZ; d++) begin
         if ((MASTER_MHZ % d == 0) && (int'(MASTER_MHZ / d) >= int'(rate)))
            res = DIV_W'(d);
      end
      return res;
   endfunction
endpackage

// File: rtl/prc_setting.sv
`timescale 1ns/100ps
module prc_setting
   import prc_pkg::*;
#(
   parameter int RATE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_active,
   input  logic              data_phase,
   input  logic [1:0]        wl_sel,
   input  logic [RATE_W-1:0] rate_req,
   output logic [1:0]        wl_cur,
   output logic [DIV_W-1:0]  div_cur,
   output logic              flush,
   output logic              reload
);
   logic in_data_q;
   logic act;
   logic start;

   assign act    = pkt_active & data_phase;
   assign start  = act & ~in_data_q;
   assign flush  = start;
   assign reload = start | (~act & in_data_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_data_q <= 1'b0;
         wl_cur    <= WL_FULL;
         div_cur   <= DIV_W'(1);
      end else begin
         in_data_q <= act;
         if (start) begin
            wl_cur  <= wl_sel;
            div_cur <= pick_divisor(32'(rate_req));
         end else if (!act) begin
            wl_cur  <= WL_FULL;
            div_cur <= DIV_W'(1);
         end
      end
   end

   assert_sync_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data_q |-> (wl_cur == WL_FULL && div_cur == DIV_W'(1)));

   assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data_q && act) |=> ($stable(wl_cur) && $stable(div_cur)));
endmodule

// File: rtl/prc_rate_div.sv
`timescale 1ns/100ps
module prc_rate_div
   import prc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             reload,
   output logic             samp_en
);
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap    = (cnt == div - DIV_W'(1));
   assign samp_en = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (reload)  cnt <= '0;
      else if (wrap)    cnt <= '0;
      else              cnt <= cnt + DIV_W'(1);
   end

   assert_en_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && div != DIV_W'(1) && !reload) |=> !samp_en);

   assert_reload_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> samp_en);
endmodule

// File: rtl/prc_requant.sv
`timescale 1ns/100ps
module prc_requant
   import prc_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int DEPTH = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            samp_en,
   input  logic            flush,
   input  logic [1:0]      wl_code,
   input  logic [IN_W-1:0] samp_in,
   output logic [IN_W-1:0] samp_out,
   output logic            out_valid
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (IN_W < 8)   begin : g_bad_w  $error("IN_W must be at least 8"); end
   if (DEPTH < 1)  begin : g_bad_d  $error("DEPTH must be at least 1"); end

   logic signed [IN_W-1:0] cand [WL_CODES];
   logic        [IN_W-1:0] stage [DEPTH];
   logic        [CNT_W-1:0] flush_cnt;

   for (genvar g = 0; g < WL_CODES; g++) begin : g_cand
      assign cand[g] = $signed(samp_in) >>> (IN_W - (1 << g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
         flush_cnt <= CNT_W'(DEPTH);
         out_valid <= 1'b0;
      end else if (samp_en) begin
         stage[0] <= cand[wl_code];
         for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
         if (flush_cnt != '0) flush_cnt <= flush_cnt - CNT_W'(1);
         out_valid <= (flush_cnt <= CNT_W'(1));
      end else begin
         out_valid <= 1'b0;
      end
   end

   assign samp_out = stage[DEPTH-1];

   assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (samp_out == '0 && !out_valid));

   assert_valid_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flush_cnt == '0);

   assert_valid_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(samp_en));
endmodule

// File: rtl/precision_rate_ctrl.sv
`timescale 1ns/100ps
module precision_rate_ctrl
   import prc_pkg::*;
#(
   parameter int IN_W       = 8,
   parameter int RATE_W     = 5,
   parameter int PIPE_DEPTH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_active,
   input  logic              data_phase,
   input  logic [1:0]        wl_sel,
   input  logic [RATE_W-1:0] rate_req,
   input  logic [IN_W-1:0]   samp_in,
   output logic              samp_en,
   output logic [IN_W-1:0]   samp_out,
   output logic              out_valid,
   output logic [1:0]        wl_active,
   output logic [DIV_W-1:0]  div_active
);
   logic flush;
   logic reload;

   prc_setting #(.RATE_W(RATE_W)) u_setting (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_active (pkt_active),
      .data_phase (data_phase),
      .wl_sel     (wl_sel),
      .rate_req   (rate_req),
      .wl_cur     (wl_active),
      .div_cur    (div_active),
      .flush      (flush),
      .reload     (reload)
   );

   prc_rate_div u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (div_active),
      .reload  (reload),
      .samp_en (samp_en)
   );

   prc_requant #(.IN_W(IN_W), .DEPTH(PIPE_DEPTH)) u_requant (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en),
      .flush     (flush),
      .wl_code   (wl_active),
      .samp_in   (samp_in),
      .samp_out  (samp_out),
      .out_valid (out_valid)
   );
endmodule

// File: tb/tb_precision_rate_ctrl.sv
`timescale 1ns/100ps
module tb_precision_rate_ctrl;
   localparam int P = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_active = 1'b0;
   logic       data_phase = 1'b0;
   logic [1:0] wl_sel = 2'd0;
   logic [4:0] rate_req = 5'd0;
   logic [7:0] samp_in = 8'd0;
   logic       samp_en;
   logic [7:0] samp_out;
   logic       out_valid;
   logic [1:0] wl_active;
   logic [4:0] div_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   precision_rate_ctrl #(.IN_W(8), .RATE_W(5), .PIPE_DEPTH(P)) dut (
      .clk(clk), .rst_n(rst_n), .pkt_active(pkt_active), .data_phase(data_phase),
      .wl_sel(wl_sel), .rate_req(rate_req), .samp_in(samp_in), .samp_en(samp_en),
      .samp_out(samp_out), .out_valid(out_valid), .wl_active(wl_active),
      .div_active(div_active)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_div(input int r);
      if (r <= 1)  return 30;
      if (r == 2)  return 15;
      if (r == 3)  return 10;
      if (r <= 5)  return 6;
      if (r == 6)  return 5;
      if (r <= 10) return 3;
      if (r <= 15) return 2;
      return 1;
   endfunction

   function automatic logic [7:0] rq(input logic [7:0] x, input int code);
      return 8'($signed(x) >>> (8 - (1 << code)));
   endfunction

   // reference model
   int         m_cnt, m_div, m_fc;
   int         m_wl;
   bit         m_in, m_valid;
   logic [7:0] m_pipe [P];

   always @(posedge clk) begin : model
      bit act, en, start;
      if (!rst_n) begin
         m_cnt = 0; m_div = 1; m_wl = 3; m_in = 0; m_fc = P; m_valid = 0;
         for (int i = 0; i < P; i++) m_pipe[i] = 8'd0;
      end else begin
         act   = pkt_active && data_phase;
         en    = (m_cnt == 0);
         start = act && !m_in;
         if (start) begin
            for (int i = 0; i < P; i++) m_pipe[i] = 8'd0;
            m_fc = P; m_valid = 0;
         end else if (en) begin
            for (int i = P - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = rq(samp_in, m_wl);
            m_valid = (m_fc <= 1);
            if (m_fc > 0) m_fc--;
         end else m_valid = 0;
         if (start || (!act && m_in)) m_cnt = 0;
         else m_cnt = (m_cnt == m_div - 1) ? 0 : m_cnt + 1;
         if (start) begin m_wl = int'(wl_sel); m_div = exp_div(int'(rate_req)); end
         else if (!act) begin m_wl = 3; m_div = 1; end
         m_in = act;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 samp_en", int'(samp_en), int'(m_cnt == 0));
         chk("R8 out_valid", int'(out_valid), int'(m_valid));
         chk("R2/R10 samp_out", int'(samp_out), int'(m_pipe[P-1]));
         chk("R6/R7 wl_active", int'(wl_active), m_wl);
         chk("R5 div_active", int'(div_active), m_div);
         samp_in <= 8'($urandom);
      end
   end

   task automatic packet(input int pre, input int dat, input int wl, input int req, input bit jitter);
      @(negedge clk);
      pkt_active = 1'b1; data_phase = 1'b0;
      for (int i = 0; i < pre; i++) begin
         @(negedge clk);
         wl_sel = 2'($urandom); rate_req = 5'($urandom);
         chk("R6 preamble wl", int'(wl_active), 3);
         chk("R6 preamble div", int'(div_active), 1);
      end
      @(negedge clk);
      wl_sel = 2'(wl); rate_req = 5'(req); data_phase = 1'b1;
      @(negedge clk);
      chk("R7 captured wl", int'(wl_active), wl);
      chk("R5 rounded div", int'(div_active), exp_div(req));
      chk("R4 first strobe", int'(samp_en), 1);
      for (int i = 0; i < dat; i++) begin
         @(negedge clk);
         if (jitter) begin wl_sel = 2'($urandom); rate_req = 5'($urandom); end
         chk("R7 held wl", int'(wl_active), wl);
         if (wl == 0 && out_valid)
            chk("R3 sign only", int'(samp_out == 8'h00 || samp_out == 8'hFF), 1);
      end
      pkt_active = 1'b0; data_phase = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R9 back to full wl", int'(wl_active), 3);
      chk("R9 back to full div", int'(div_active), 1);
      chk("R9 strobe every cycle", int'(samp_en), 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset wl", int'(wl_active), 3);
      chk("R1 reset div", int'(div_active), 1);
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset out", int'(samp_out), 0);
      // directed rounding and mode corners
      packet(4, 40, 0, 2, 1'b1);
      packet(3, 30, 1, 13, 1'b0);
      packet(2, 90, 2, 0, 1'b1);
      packet(5, 20, 3, 31, 1'b0);
      packet(1, 25, 0, 16, 1'b1);
      packet(2, 40, 3, 4, 1'b0);
      packet(2, 2, 1, 30, 1'b1);
      // constrained random packets
      for (int k = 0; k < 40; k++) begin
         packet(1 + int'($urandom % 12), 1 + int'($urandom % 80),
                int'($urandom % 4), int'($urandom % 32), 1'($urandom));
         repeat (int'($urandom % 3)) @(negedge clk);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule